// File: doc/BRIEF.md
# Bus Turnaround Idle Cycle Inserter

This block stands between the request path of a bus master and an external memory bus. Before each new bus cycle starts, it decides how many idle cycles the bus must rest. The decision uses three things: the region and direction of the access that completed last, the region and direction of the access now requested, and a programmed 3-bit idle count. Idle cycles are inserted only when the previous access went to one of the DRAM chip-select regions. Some transitions carry a fixed minimum that applies even when the programmed count is zero:

- leaving the region after a read needs at least one idle cycle;
- leaving the region after a write needs at least two;
- a write that follows a read in the same region needs at least two.

The count actually used is the larger of the programmed value and that minimum.

A requester raises `req_valid` with the region and direction of its access and holds them steady until `grant` is high at a clock edge. That edge starts the bus cycle, and `bus_start` is high during the cycle that leads up to it. While idle cycles are being counted, `grant` stays low and `idle_active` is high. The programmed count lives in a small configuration register loaded through `cfg_wr_en`/`cfg_wr_data`. The value of that register is sampled when a request is evaluated.

Top module: `bus_turn_idle`

## Requirements
- R1: The idle-count register resets to 7 (binary 111), so a DRAM-region read followed by a read to the same region waits 7 idle cycles before any write to the register.
- R2: Within one DRAM region, read after read, write after write and read after write wait exactly the programmed count (the code value equals the idle cycles, 0 to 7).
- R3: After a DRAM-region read, a request to any other region (DRAM or not) waits max(programmed, 1) idle cycles.
- R4: After a DRAM-region write, a request to any other region waits max(programmed, 2) idle cycles.
- R5: A write following a read within the same DRAM region waits max(programmed, 2) idle cycles.
- R6: When the previous access went to a region other than the two DRAM regions (default region codes 4 and 5 of a 3-bit region field), no idle cycles are inserted and `grant` rises on the clock edge that evaluates the request.
- R7: The first access after reset gets no idle cycles, whatever its region.
- R8: While idle cycles count, `grant` and `bus_start` stay low. `grant` rises on the edge after the count reaches zero, stays high until the request is taken, and drops on the edge that takes it.
- R9: A write to the idle-count register while idle cycles are counting leaves that sequence's length unchanged; the new value applies from the next evaluation.
- R10: `idle_active` is high in exactly the cycles in which an inserted idle cycle holds the request back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Load the idle-count register |
| cfg_wr_data | input | 3 | New programmed idle count |
| req_valid | input | 1 | A bus cycle is requested |
| req_region | input | 3 | Region code of the requested access |
| req_write | input | 1 | 1 = write, 0 = read |
| grant | output | 1 | Requested cycle may start at this edge |
| bus_start | output | 1 | High in the cycle before the edge that starts a bus cycle |
| idle_active | output | 1 | An inserted idle cycle is in progress |

## Verification
The number of idle cycles is measured at the ports as the edges between the request and the rise of `grant`. It is checked over directed transitions that separate each case:

- same-region read/read, write/write and read/write;
- read-then-write in the same region;
- leaving after a read and leaving after a write, to both a DRAM and a non-DRAM region;
- a non-DRAM predecessor;
- the first access after reset.

Each case is run with a programmed count both below and above its minimum, so that an implementation that adds the minimum, or ignores it, is caught. Random regions, directions and counts then mix all the cases against a bench model. A directed register write during a count checks that the count in progress keeps its length.

// File: rtl/bti_pkg.sv
package bti_pkg;

    localparam int RGN_W  = 3;
    localparam int IDLE_W = 3;

    typedef enum logic [1:0] {
        ST_EVAL  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_GRANT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             vld;
        logic [RGN_W-1:0] rgn;
        logic             wr;
    } access_t;

    function automatic logic [IDLE_W-1:0] max_idle(input logic [IDLE_W-1:0] a,
                                                   input logic [IDLE_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bti_cfg_reg.sv
module bti_cfg_reg #(
    parameter int                IDLE_W  = 3,
    parameter logic [IDLE_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDLE_W-1:0] wr_data,
    output logic [IDLE_W-1:0] idle_cfg
);

    typedef struct packed {
        logic [IDLE_W-1:0] cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.cnt = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.cnt <= RST_VAL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign idle_cfg = cfg_q.cnt;

endmodule

// File: rtl/bti_history.sv
module bti_history
    import bti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [RGN_W-1:0] rgn,
    input  logic             wr,
    output access_t          last
);

    access_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (take) begin
            hist_d.vld = 1'b1;
            hist_d.rgn = rgn;
            hist_d.wr  = wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign last = hist_q;

endmodule

// File: rtl/bti_turn_calc.sv
module bti_turn_calc
    import bti_pkg::*;
#(
    parameter int                       NUM_DRAM   = 2,
    parameter logic [NUM_DRAM*RGN_W-1:0] DRAM_RGNS = {3'd5, 3'd4},
    parameter logic [IDLE_W-1:0]        MIN_RD_OUT = 3'd1,
    parameter logic [IDLE_W-1:0]        MIN_WR_OUT = 3'd2,
    parameter logic [IDLE_W-1:0]        MIN_RD_WR  = 3'd2
) (
    input  access_t           last,
    input  logic [RGN_W-1:0]  nxt_rgn,
    input  logic              nxt_wr,
    input  logic [IDLE_W-1:0] idle_cfg,
    output logic [IDLE_W-1:0] need
);

    logic [NUM_DRAM-1:0] hit;

    for (genvar g = 0; g < NUM_DRAM; g++) begin : g_dram_match
        assign hit[g] = (last.rgn == DRAM_RGNS[g*RGN_W +: RGN_W]);
    end

    logic last_dram;
    logic leaving;
    logic rd_to_wr;

    always_comb begin
        last_dram = last.vld && (|hit);
        leaving   = (nxt_rgn != last.rgn);
        rd_to_wr  = !last.wr && nxt_wr;
        need      = '0;
        if (last_dram) begin
            if (leaving) begin
                need = last.wr ? max_idle(idle_cfg, MIN_WR_OUT)
                               : max_idle(idle_cfg, MIN_RD_OUT);
            end else if (rd_to_wr) begin
                need = max_idle(idle_cfg, MIN_RD_WR);
            end else begin
                need = idle_cfg;
            end
        end
    end

endmodule

// File: rtl/bti_seq.sv
module bti_seq
    import bti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDLE_W-1:0] need,
    output logic              grant,
    output logic              idle_active
);

    typedef struct packed {
        seq_state_e        state;
        logic [IDLE_W-1:0] cnt;
        logic              grant;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_EVAL: begin
                if (req_valid) begin
                    if (need == '0) begin
                        seq_d.state = ST_GRANT;
                        seq_d.grant = 1'b1;
                    end else begin
                        seq_d.state = ST_IDLE;
                        seq_d.cnt   = need;
                    end
                end
            end
            ST_IDLE: begin
                if (seq_q.cnt <= 1) begin
                    seq_d.state = ST_GRANT;
                    seq_d.cnt   = '0;
                    seq_d.grant = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_GRANT: begin
                if (req_valid) begin
                    seq_d.state = ST_EVAL;
                    seq_d.grant = 1'b0;
                end
            end
            default: begin
                seq_d.state = ST_EVAL;
                seq_d.cnt   = '0;
                seq_d.grant = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_EVAL;
            seq_q.cnt   <= '0;
            seq_q.grant <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign grant       = seq_q.grant;
    assign idle_active = (seq_q.state == ST_IDLE);

endmodule

// File: rtl/bus_turn_idle.sv
module bus_turn_idle
    import bti_pkg::*;
#(
    parameter int                        NUM_DRAM   = 2,
    parameter logic [NUM_DRAM*RGN_W-1:0] DRAM_RGNS  = {3'd5, 3'd4},
    parameter logic [IDLE_W-1:0]         CFG_RST    = 3'd7,
    parameter logic [IDLE_W-1:0]         MIN_RD_OUT = 3'd1,
    parameter logic [IDLE_W-1:0]         MIN_WR_OUT = 3'd2,
    parameter logic [IDLE_W-1:0]         MIN_RD_WR  = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDLE_W-1:0] cfg_wr_data,
    input  logic              req_valid,
    input  logic [RGN_W-1:0]  req_region,
    input  logic              req_write,
    output logic              grant,
    output logic              bus_start,
    output logic              idle_active
);

    logic [IDLE_W-1:0] idle_cfg;
    logic [IDLE_W-1:0] need;
    access_t           last;
    logic              take;

    assign take      = req_valid && grant;
    assign bus_start = take;

    bti_cfg_reg #(
        .IDLE_W  (IDLE_W),
        .RST_VAL (CFG_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .idle_cfg (idle_cfg)
    );

    bti_history u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .rgn   (req_region),
        .wr    (req_write),
        .last  (last)
    );

    bti_turn_calc #(
        .NUM_DRAM   (NUM_DRAM),
        .DRAM_RGNS  (DRAM_RGNS),
        .MIN_RD_OUT (MIN_RD_OUT),
        .MIN_WR_OUT (MIN_WR_OUT),
        .MIN_RD_WR  (MIN_RD_WR)
    ) u_calc (
        .last     (last),
        .nxt_rgn  (req_region),
        .nxt_wr   (req_write),
        .idle_cfg (idle_cfg),
        .need     (need)
    );

    bti_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .need        (need),
        .grant       (grant),
        .idle_active (idle_active)
    );

endmodule

// File: rtl/bus_turn_idle_chk.sv
module bus_turn_idle_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic grant,
    input logic bus_start,
    input logic idle_active
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (idle_active) begin
            run_q <= run_q + 4'd1;
        end else begin
            run_q <= '0;
        end
    end

    a_r8_no_grant_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_active |-> (!grant && !bus_start));

    a_r8_grant_drops_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !grant);

    a_r8_grant_holds_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !req_valid) |=> grant);

    a_r10_idle_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        idle_active |-> req_valid);

    a_r2_idle_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 4'd7);

    a_r10_no_idle_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !idle_active);

endmodule

bind bus_turn_idle bus_turn_idle_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .grant       (grant),
    .bus_start   (bus_start),
    .idle_active (idle_active)
);

// File: tb/bus_turn_idle_tb.sv
module bus_turn_idle_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_data = '0;
    logic       req_valid = 1'b0;
    logic [2:0] req_region = '0;
    logic       req_write = 1'b0;
    logic       grant;
    logic       bus_start;
    logic       idle_active;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the previous access and the programmed count
    bit       m_vld = 1'b0;
    bit [2:0] m_rgn = '0;
    bit       m_wr  = 1'b0;
    int       m_cfg = 7;

    always #2 clk = ~clk;

    bus_turn_idle u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .req_valid   (req_valid),
        .req_region  (req_region),
        .req_write   (req_write),
        .grant       (grant),
        .bus_start   (bus_start),
        .idle_active (idle_active)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_idle(bit pv, bit [2:0] pr, bit pw,
                                    bit [2:0] nr, bit nw, int cfg);
        if (!pv || !(pr == 3'd4 || pr == 3'd5)) return 0;
        if (nr != pr) return pw ? imax(cfg, 2) : imax(cfg, 1);
        if (!pw && nw) return imax(cfg, 2);
        return cfg;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(int v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v[2:0];
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        m_cfg       = v;
    endtask

    // one access; mid_cfg >= 0 writes the register during the idle count
    task automatic access(bit [2:0] rgn, bit wr, string req, int mid_cfg);
        int  exp;
        int  waits;
        bit  bad_idle;
        exp      = exp_idle(m_vld, m_rgn, m_wr, rgn, wr, m_cfg);
        waits    = 0;
        bad_idle = 1'b0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_region = rgn;
        req_write  = wr;
        forever begin
            @(posedge clk);
            @(negedge clk);
            cfg_wr_en = 1'b0;
            if (grant) break;
            if (!idle_active || bus_start) bad_idle = 1'b1;
            waits++;
            if (mid_cfg >= 0 && waits == 1) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_data = mid_cfg[2:0];
            end
            if (waits > 20) break;
        end
        check(req, waits, exp);
        check("R10 idle_active/bus_start during wait", int'(bad_idle), 0);
        check("R8 bus_start with grant", int'(bus_start), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 grant drops after take", int'(grant), 0);
        check("R10 idle_active after take", int'(idle_active), 0);
        if (mid_cfg >= 0) m_cfg = mid_cfg;
        m_vld = 1'b1;
        m_rgn = rgn;
        m_wr  = wr;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7301));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("reset grant", int'(grant), 0);
        check("reset idle_active", int'(idle_active), 0);
        check("reset bus_start", int'(bus_start), 0);

        access(3'd4, 1'b0, "R7 first access", -1);
        access(3'd4, 1'b0, "R1 reset count 7", -1);

        write_cfg(0);
        access(3'd4, 1'b0, "R2 rd-rd cfg0", -1);
        access(3'd4, 1'b1, "R5 rd-wr cfg0", -1);
        access(3'd4, 1'b1, "R2 wr-wr cfg0", -1);
        access(3'd4, 1'b0, "R2 wr-rd cfg0", -1);
        access(3'd1, 1'b0, "R3 rd leave cfg0", -1);
        access(3'd5, 1'b1, "R6 non-DRAM prev", -1);
        access(3'd4, 1'b0, "R4 wr leave to DRAM cfg0", -1);
        access(3'd5, 1'b0, "R3 rd leave to DRAM cfg0", -1);
        access(3'd5, 1'b1, "R5 rd-wr cfg0 region5", -1);
        access(3'd2, 1'b1, "R4 wr leave cfg0", -1);

        write_cfg(1);
        access(3'd5, 1'b0, "R6 non-DRAM prev cfg1", -1);
        access(3'd5, 1'b1, "R5 rd-wr cfg1", -1);
        access(3'd0, 1'b0, "R4 wr leave cfg1", -1);

        write_cfg(3);
        access(3'd4, 1'b1, "R6 non-DRAM prev cfg3", -1);
        access(3'd4, 1'b1, "R2 wr-wr cfg3", -1);
        access(3'd6, 1'b0, "R4 wr leave cfg3", -1);
        access(3'd4, 1'b0, "R6 non-DRAM prev", -1);
        access(3'd7, 1'b0, "R3 rd leave cfg3", -1);
        access(3'd5, 1'b0, "R6 before R9", -1);

        write_cfg(6);
        access(3'd5, 1'b0, "R9 mid-count write keeps 6", 0);
        access(3'd5, 1'b0, "R9 new count applies", -1);

        for (int i = 0; i < 300; i++) begin
            bit [2:0] r;
            bit       w;
            if (($urandom % 8) == 0) write_cfg(int'($urandom % 8));
            r = (($urandom % 2) == 0) ? (3'd4 + 3'(($urandom % 2))) : 3'($urandom % 8);
            w = 1'($urandom % 2);
            access(r, w, "R2-R6 random mix", -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule